// File: doc/BRIEF.md
# Power-On Reset Pulse Generator

This block turns a digital "supply is above its trip level" indication into a single internal reset pulse of fixed width. A comparator outside the block produces the indication, and the block samples it on a free-running clock. The reset output is low out of reset. When the indication is seen high while the generator is armed, the output rises and stays high for a fixed number of clock cycles. It then drops, even if the supply remains good.

After a pulse the generator is disarmed. It arms again only after the supply indication has been low for at least a minimum number of consecutive sampled cycles. A shorter low excursion is treated as a glitch and changes nothing. A low excursion that begins while a pulse is still being driven does not cut that pulse short. It only counts toward re-arming, and a qualified one takes effect when the pulse ends.

The indication passes through a two-stage synchroniser before any logic uses it. A status output shows when the generator is armed and waiting for a rising supply.

Top module: `por_pulse_gen`

## Requirements
- R1: While `rst` is sampled high and on the first cycle after it, `por_o` is 0 and `armed_o` is 1.
- R2: When `supply_ok` goes from 0 to 1 while `armed_o` is 1, `por_o` reads 1 after the third rising clock edge that samples `supply_ok` high, and not before. The delay comes from two synchroniser stages plus one register.
- R3: Each pulse keeps `por_o` at 1 for exactly `PULSE_CYC` consecutive cycles. After that `por_o` returns to 0 while `supply_ok` stays 1.
- R4: After a pulse with no qualified low excursion, `por_o` stays 0 and `armed_o` stays 0, however long `supply_ok` stays high.
- R5: If `supply_ok` is low for at least `MIN_LOW` consecutive sampled cycles outside a pulse, `armed_o` becomes 1. The next rise of `supply_ok` then produces a pulse as in R2 and R3.
- R6: A low excursion of exactly `MIN_LOW` sampled cycles re-arms the generator. A low excursion of `MIN_LOW-1` cycles does not, and no pulse follows.
- R7: A low excursion that starts during a pulse leaves that pulse exactly `PULSE_CYC` cycles wide. If the excursion lasts `MIN_LOW` cycles or more, a new pulse starts once the old one has ended and `supply_ok` is high. If it is shorter, no new pulse follows.
- R8: `armed_o` and `por_o` are never 1 in the same cycle.
- R9: Asserting `rst` during a pulse forces `por_o` to 0 after the next clock edge. With `supply_ok` high when `rst` is released, a full pulse follows with the R2 latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sampling clock |
| rst | input | 1 | Synchronous active-high test reset; arms the generator |
| supply_ok | input | 1 | Asynchronous indication that the supply is above its trip level |
| por_o | output | 1 | Active-high reset pulse |
| armed_o | output | 1 | Status: generator waits for a rising supply indication |

## Verification
A corrupted low-run counter shows up at the ports as a wrong verdict on a dip. A dip of `MIN_LOW-1` cycles that produces a pulse, or a dip of exactly `MIN_LOW` cycles that does not, is visible within one pulse width. For that reason both boundary lengths are driven, both outside and inside a pulse.

A wrong pulse timer changes the measured width of `por_o` on the very first pulse. A state register stuck in the wrong state shows up either as `armed_o` and `por_o` high together or as an extra or missing pulse within a few cycles. The R2 latency is counted edge by edge, so a missing or extra synchroniser stage changes the count by one.

// File: rtl/por_pkg.sv
package por_pkg;

    typedef enum logic [1:0] {
        PG_ARMED = 2'd0,
        PG_PULSE = 2'd1,
        PG_WAIT  = 2'd2
    } pg_state_e;

    typedef struct packed {
        pg_state_e state;
        logic      rearm;
    } pg_ctrl_t;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/por_sync.sv
module por_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES < 2) begin : g_bad
            $error("por_sync: STAGES must be at least 2");
        end
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/por_low_qual.sv
module por_low_qual
    import por_pkg::*;
#(
    parameter int unsigned MIN_LOW = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_hi,
    output logic qual_evt
);
    localparam int unsigned LW = cnt_width(MIN_LOW);
    localparam logic [LW-1:0] LIMIT   = LW'(MIN_LOW);
    localparam logic [LW-1:0] PRE_LIM = LW'(MIN_LOW - 1);

    logic [LW-1:0] run_q;
    logic          evt_q;

    generate
        if (MIN_LOW < 1) begin : g_bad
            $error("por_low_qual: MIN_LOW must be at least 1");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            evt_q <= 1'b0;
        end else if (supply_hi) begin
            run_q <= '0;
            evt_q <= 1'b0;
        end else begin
            if (run_q != LIMIT) run_q <= run_q + 1'b1;
            evt_q <= (run_q == PRE_LIM);
        end
    end

    assign qual_evt = evt_q;

    // R6: a qualification event only follows a low sample
    assert_qual_after_low_R6: assert property (@(posedge clk) disable iff (rst)
        qual_evt |-> $past(!supply_hi));

    // R6: the event is a single-cycle strobe per low run
    assert_qual_single_R6: assert property (@(posedge clk) disable iff (rst)
        qual_evt |=> !qual_evt);
endmodule

// File: rtl/por_pulse_timer.sv
module por_pulse_timer
    import por_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int unsigned CW = cnt_width(PULSE_CYC);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC - 1);

    logic [CW-1:0] left_q;
    logic          busy_q;

    generate
        if (PULSE_CYC < 1) begin : g_bad
            $error("por_pulse_timer: PULSE_CYC must be at least 1");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            left_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            left_q <= LOAD;
        end else if (busy_q) begin
            if (left_q == '0) busy_q <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign last = busy_q && (left_q == '0);

    // R3: a running pulse is never cut short before its last cycle
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !last && !start) |=> busy);

    // R3: the pulse ends after its last cycle
    assert_end_R3: assert property (@(posedge clk) disable iff (rst)
        (last && !start) |=> !busy);
endmodule

// File: rtl/por_pulse_gen.sv
module por_pulse_gen
    import por_pkg::*;
#(
    parameter int unsigned PULSE_CYC   = 16,
    parameter int unsigned MIN_LOW     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    output logic por_o,
    output logic armed_o
);
    logic     supply_hi;
    logic     qual_evt;
    logic     fire;
    logic     t_busy;
    logic     t_last;
    pg_ctrl_t ctrl_q, ctrl_d;

    por_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (supply_ok),
        .q_sync  (supply_hi)
    );

    por_low_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .supply_hi (supply_hi),
        .qual_evt  (qual_evt)
    );

    por_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (fire),
        .busy  (t_busy),
        .last  (t_last)
    );

    assign fire = (ctrl_q.state == PG_ARMED) && supply_hi;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.state)
            PG_ARMED: if (supply_hi) ctrl_d.state = PG_PULSE;
            PG_PULSE: if (t_last)
                          ctrl_d.state = (ctrl_q.rearm || qual_evt) ? PG_ARMED : PG_WAIT;
            PG_WAIT:  if (ctrl_q.rearm || qual_evt) ctrl_d.state = PG_ARMED;
            default:  ctrl_d.state = PG_ARMED;
        endcase
        if (ctrl_d.state == PG_ARMED || ctrl_q.state == PG_ARMED)
            ctrl_d.rearm = 1'b0;
        else if (qual_evt)
            ctrl_d.rearm = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.state <= PG_ARMED;
            ctrl_q.rearm <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign por_o   = t_busy;
    assign armed_o = (ctrl_q.state == PG_ARMED);

    // R1: first cycle after reset is quiet and armed
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!por_o && armed_o));

    // R2: armed and supply seen high starts the pulse on the next edge
    assert_fire_R2: assert property (@(posedge clk) disable iff (rst)
        (armed_o && supply_hi) |=> por_o);

    // R4: a pulse only ever begins from the armed state
    assert_no_refire_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(por_o) |-> $past(armed_o));

    // R5: a qualified dip while waiting arms the generator
    assert_rearm_R5: assert property (@(posedge clk) disable iff (rst)
        (qual_evt && ctrl_q.state == PG_WAIT) |=> armed_o);

    // R7: the controller and the timer agree on whether a pulse runs
    assert_pulse_agree_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.state == PG_PULSE) == t_busy);

    // R8: armed and pulsing are exclusive
    assert_flags_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(por_o && armed_o));

    // R9: reset during a pulse clears it at the next edge
    assert_reset_drop_R9: assert property (@(posedge clk)
        $past(rst) |-> !por_o);
endmodule

// File: tb/por_pulse_gen_tb.sv
module por_pulse_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P = 16;
    localparam int M = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0;
    logic por_o;
    logic armed_o;

    int checks = 0;
    int errors = 0;

    por_pulse_gen #(.PULSE_CYC(P), .MIN_LOW(M), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .por_o     (por_o),
        .armed_o   (armed_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_high(input int maxc, output int n);
        n = 0;
        while (!por_o && n < maxc) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_high(output int w);
        w = 0;
        while (por_o && w < 1000) begin
            @(negedge clk);
            w++;
        end
    endtask

    // counts cycles in which por_o is seen high over a window
    task automatic quiet_window(input int len, output int highs);
        highs = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (por_o) highs++;
        end
    endtask

    task automatic dip(input int d);
        supply_ok = 1'b0;
        repeat (d) @(negedge clk);
        supply_ok = 1'b1;
    endtask

    // long dip, then rise and wait for the pulse to start
    task automatic rearm_and_fire(output int n);
        dip(M + 4);
        wait_high(M + 20, n);
    endtask

    task automatic t_reset_state;
        rst = 1'b1;
        supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        chk(por_o == 1'b0, "R1 por_o in reset", por_o, 0);
        chk(armed_o == 1'b1, "R1 armed_o in reset", armed_o, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(por_o == 1'b0 && armed_o == 1'b1, "R1 after release", {por_o, armed_o}, 1);
    endtask

    task automatic t_first_pulse;
        int n, w, h;
        supply_ok = 1'b1;
        wait_high(20, n);
        chk(n == 3, "R2 first rise latency", n, 3);
        chk(armed_o == 1'b0, "R8 armed low during pulse", armed_o, 0);
        count_high(w);
        chk(w == P, "R3 pulse width", w, P);
        quiet_window(3 * P, h);
        chk(h == 0, "R4 no pulse while supply stays high", h, 0);
        chk(armed_o == 1'b0, "R4 not armed after pulse", armed_o, 0);
    endtask

    task automatic t_short_dip;
        int h;
        dip(M - 1);
        quiet_window(3 * P, h);
        chk(h == 0, "R6 dip MIN_LOW-1 ignored", h, 0);
        chk(armed_o == 1'b0, "R6 dip MIN_LOW-1 leaves disarmed", armed_o, 0);
    endtask

    task automatic t_exact_dip;
        int n, w;
        dip(M);
        wait_high(M + 20, n);
        chk(por_o == 1'b1, "R6 dip MIN_LOW qualifies", por_o, 1);
        count_high(w);
        chk(w == P, "R6 width after exact dip", w, P);
    endtask

    task automatic t_long_dip;
        int n, w;
        supply_ok = 1'b0;
        repeat (M + 6) @(negedge clk);
        chk(armed_o == 1'b1, "R5 armed after long dip", armed_o, 1);
        chk(por_o == 1'b0, "R8 no pulse while armed", por_o, 0);
        supply_ok = 1'b1;
        wait_high(20, n);
        chk(n == 3, "R5 rise latency when armed", n, 3);
        count_high(w);
        chk(w == P, "R5 width after re-arm", w, P);
    endtask

    task automatic t_dip_in_pulse(input int dlen, input bit expect_refire);
        int n, w, h;
        rearm_and_fire(n);
        w = 0;
        while (por_o && w < 1000) begin
            supply_ok = !(w >= 2 && w < 2 + dlen);
            @(negedge clk);
            w++;
        end
        supply_ok = 1'b1;
        chk(w == P, "R7 pulse not shortened by dip", w, P);
        if (expect_refire) begin
            wait_high(10, n);
            chk(por_o == 1'b1, "R7 qualified dip in pulse re-fires", por_o, 1);
            count_high(w);
            chk(w == P, "R7 width of follow-up pulse", w, P);
        end else begin
            quiet_window(3 * P, h);
            chk(h == 0, "R7 short dip in pulse no re-fire", h, 0);
        end
    endtask

    task automatic t_reset_mid_pulse;
        int n, w;
        rearm_and_fire(n);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(por_o == 1'b0, "R9 reset drops pulse", por_o, 0);
        chk(armed_o == 1'b1, "R9 reset arms", armed_o, 1);
        rst = 1'b0;
        wait_high(20, n);
        chk(n == 3, "R9 latency after reset release", n, 3);
        count_high(w);
        chk(w == P, "R9 full pulse after reset", w, P);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_first_pulse();
        t_short_dip();
        t_exact_dip();
        t_long_dip();
        t_dip_in_pulse(M + 2, 1'b1);
        t_dip_in_pulse(M - 1, 1'b0);
        t_reset_mid_pulse();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule